// File: doc/BRIEF.md
# Sequential Canonical Signed-Digit Recoder

This block turns a two's-complement integer of `WIDTH` bits into its canonical signed-digit form, in which every digit is -1, 0 or +1 and no two neighbouring digits are both non-zero. The result has the fewest non-zero digits of any signed-digit form of the value. A constant-coefficient multiplier generator can use it to find the minimum number of add and subtract steps for a coefficient.

The recoder handles one digit position per clock, starting with the least significant. First it widens the operand by one copy of its sign bit. Then, at each position, a three-input lookup reads the next higher bit, the current bit and a running carry. The lookup returns the digit and the carry for the next position. A one-clock `start` loads the operand. `WIDTH` clocks later `done` pulses, and from then on the digit flags and the non-zero digit count hold steady until the next accepted `start`.

Top module: `csd_recoder`

## Requirements
- R1: After reset, `busy`, `done`, every digit flag and `nz_count` are all zero.
- R2: The operand is widened with its own sign bit, so negative inputs recode correctly. The most negative input, -2^(WIDTH-1), gives a single -1 in position WIDTH-1 and zeros everywhere else.
- R3: Position i is encoded by the pair {`dig_nz[i]`, `dig_neg[i]`}: 00 means 0, 10 means +1, 11 means -1. For every input the digit set equals the unique non-adjacent form of the signed value.
- R4: The pair 01 (negative flag set without the non-zero flag) never appears at any position.
- R5: The sum over all positions of digit[i]·2^i equals the signed input value.
- R6: In a finished result, no two adjacent positions are both non-zero.
- R7: When `done` is high, `nz_count` equals the number of positions whose `dig_nz` is set.
- R8: `start` is accepted at a clock edge where `busy` is low. `done` is then high for exactly one cycle, beginning right after the WIDTH-th rising edge that follows the accepting edge.
- R9: A `start` raised while `busy` is high is ignored. Neither the result of the current conversion nor the time at which it completes changes.
- R10: While the block is idle and `start` is low, the digit flags and `nz_count` keep their values, whatever `value` does.
- R11: `busy` is high for the WIDTH cycles after an accepting edge and is low in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion of `value` (taken only when idle) |
| value | input | WIDTH | Two's-complement operand |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result is final |
| dig_nz | output | WIDTH | Per-position non-zero flag |
| dig_neg | output | WIDTH | Per-position negative flag (valid with `dig_nz`) |
| nz_count | output | $clog2(WIDTH+1) | Number of non-zero digits |

## Verification
Call the edge that accepts `start` edge k. `done` and the final digits and count are due just after edge k+WIDTH, and `busy` is due just after edge k. The bench counts falling edges from the one at which it releases `start`. It expects `done` low at every earlier falling edge and high at the WIDTH-th. It compares the result at that same falling edge, and one edge later it confirms that `done` has dropped. For the hold and ignore cases, the bench samples the outputs at falling edges after it has disturbed `value` or raised `start`, so a digit that is overwritten shows up in the very next comparison.

// File: rtl/csd_pkg.sv
package csd_pkg;

   typedef struct packed {
      logic nz;
      logic neg;
   } csd_digit_t;

   localparam csd_digit_t CSD_ZERO = '{nz: 1'b0, neg: 1'b0};
   localparam csd_digit_t CSD_PLUS = '{nz: 1'b1, neg: 1'b0};
   localparam csd_digit_t CSD_MINUS = '{nz: 1'b1, neg: 1'b1};

   typedef enum logic {
      RC_IDLE = 1'b0,
      RC_RUN  = 1'b1
   } rc_state_t;

endpackage

// File: rtl/csd_step_lut.sv
module csd_step_lut
   import csd_pkg::*;
(
   input  logic       bit_hi,
   input  logic       bit_lo,
   input  logic       carry_in,
   output csd_digit_t digit,
   output logic       carry_out
);

   logic [2:0] sel;
   assign sel = {bit_hi, bit_lo, carry_in};

   always_comb begin
      digit     = CSD_ZERO;
      carry_out = 1'b0;
      unique case (sel)
         3'd0, 3'd4: begin digit = CSD_ZERO;  carry_out = 1'b0; end
         3'd1, 3'd2: begin digit = CSD_PLUS;  carry_out = 1'b0; end
         3'd3, 3'd7: begin digit = CSD_ZERO;  carry_out = 1'b1; end
         3'd5, 3'd6: begin digit = CSD_MINUS; carry_out = 1'b1; end
         default:    begin digit = CSD_ZERO;  carry_out = 1'b0; end
      endcase
   end

endmodule

// File: rtl/csd_operand_shifter.sv
module csd_operand_shifter #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             shift,
   input  logic [WIDTH-1:0] value,
   output logic             bit_lo,
   output logic             bit_hi
);

   localparam int EXT_W = WIDTH + 1;

   logic [EXT_W-1:0] ext_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ext_q <= '0;
      end else if (load) begin
         ext_q <= {value[WIDTH-1], value};
      end else if (shift) begin
         ext_q <= {ext_q[EXT_W-1], ext_q[EXT_W-1:1]};
      end
   end

   assign bit_lo = ext_q[0];
   assign bit_hi = ext_q[1];

endmodule

// File: rtl/csd_digit_bank.sv
module csd_digit_bank
   import csd_pkg::*;
#(
   parameter int WIDTH = 16,
   localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             wr_en,
   input  logic [PW-1:0]    wr_pos,
   input  csd_digit_t       wr_digit,
   output logic [WIDTH-1:0] nz,
   output logic [WIDTH-1:0] neg
);

   for (genvar g = 0; g < WIDTH; g++) begin : g_pos
      csd_digit_t slot_q;

      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            slot_q <= CSD_ZERO;
         end else if (wr_en && (wr_pos == PW'(g))) begin
            slot_q <= wr_digit;
         end
      end

      assign nz[g]  = slot_q.nz;
      assign neg[g] = slot_q.neg;

      AST_NO_BARE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
         !(neg[g] && !nz[g])); // R4
   end

endmodule

// File: rtl/csd_weight_counter.sv
module csd_weight_counter #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          inc,
   output logic [CW-1:0] count
);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         count <= '0;
      end else if (inc) begin
         count <= count + CW'(1);
      end
   end

endmodule

// File: rtl/csd_recoder.sv
module csd_recoder
   import csd_pkg::*;
#(
   parameter int WIDTH = 16,
   localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1,
   localparam int CW = $clog2(WIDTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] value,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] dig_nz,
   output logic [WIDTH-1:0] dig_neg,
   output logic [CW-1:0]    nz_count
);

   localparam logic [PW-1:0] LAST_POS = PW'(WIDTH - 1);

   if (WIDTH < 2) begin : g_bad_width
      $error("csd_recoder: WIDTH must be at least 2");
   end

   rc_state_t  state_q;
   logic [PW-1:0] pos_q;
   logic       carry_q;
   logic       done_q;
   logic       accept;
   logic       bit_lo;
   logic       bit_hi;
   csd_digit_t step_digit;
   logic       step_carry;

   assign busy   = (state_q == RC_RUN);
   assign accept = start && !busy;
   assign done   = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RC_IDLE;
         pos_q   <= '0;
         carry_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            RC_IDLE: begin
               if (start) begin
                  state_q <= RC_RUN;
                  pos_q   <= '0;
                  carry_q <= 1'b0;
               end
            end
            RC_RUN: begin
               carry_q <= step_carry;
               if (pos_q == LAST_POS) begin
                  state_q <= RC_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  pos_q <= pos_q + PW'(1);
               end
            end
            default: state_q <= RC_IDLE;
         endcase
      end
   end

   csd_operand_shifter #(.WIDTH(WIDTH)) u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .shift  (busy),
      .value  (value),
      .bit_lo (bit_lo),
      .bit_hi (bit_hi)
   );

   csd_step_lut u_lut (
      .bit_hi    (bit_hi),
      .bit_lo    (bit_lo),
      .carry_in  (carry_q),
      .digit     (step_digit),
      .carry_out (step_carry)
   );

   csd_digit_bank #(.WIDTH(WIDTH)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (accept),
      .wr_en    (busy),
      .wr_pos   (pos_q),
      .wr_digit (step_digit),
      .nz       (dig_nz),
      .neg      (dig_neg)
   );

   csd_weight_counter #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .inc   (busy && step_digit.nz),
      .count (nz_count)
   );

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy)); // R11
   AST_COUNT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (nz_count == CW'($countones(dig_nz)))); // R7
   AST_NON_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((dig_nz & (dig_nz >> 1)) == '0)); // R6
   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && (pos_q != LAST_POS)) |=> (busy && (pos_q == $past(pos_q) + PW'(1)))); // R9
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(dig_nz) && $stable(dig_neg) && $stable(nz_count))); // R10

endmodule

// File: tb/csd_recoder_test.sv
module csd_recoder_test;

   localparam int WIDTH = 16;
   localparam int CW = $clog2(WIDTH + 1);
   localparam time CLK_PERIOD = 10ns;
   localparam int RANDOM_RUNS = 3000;
   localparam int WATCHDOG_CYCLES = 190000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [WIDTH-1:0] value = '0;
   logic             busy;
   logic             done;
   logic [WIDTH-1:0] dig_nz;
   logic [WIDTH-1:0] dig_neg;
   logic [CW-1:0]    nz_count;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   csd_recoder #(.WIDTH(WIDTH)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .value    (value),
      .busy     (busy),
      .done     (done),
      .dig_nz   (dig_nz),
      .dig_neg  (dig_neg),
      .nz_count (nz_count)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // non-adjacent form by repeated halving of the signed value
   function automatic void ref_csd(input logic [WIDTH-1:0] v,
                                   output logic [WIDTH-1:0] enz,
                                   output logic [WIDTH-1:0] eneg);
      int x;
      int d;
      x = int'($signed(v));
      enz = '0;
      eneg = '0;
      for (int i = 0; i < WIDTH; i++) begin
         if ((x & 1) != 0) begin
            d = 2 - (x & 3);
            enz[i] = 1'b1;
            eneg[i] = (d < 0);
            x = x - d;
         end
         x = x >>> 1;
      end
   endfunction

   function automatic longint weigh(input logic [WIDTH-1:0] nz, input logic [WIDTH-1:0] ng);
      longint s = 0;
      for (int i = 0; i < WIDTH; i++)
         if (nz[i]) s += ng[i] ? -(longint'(1) << i) : (longint'(1) << i);
      return s;
   endfunction

   task automatic check_result(input logic [WIDTH-1:0] v);
      logic [WIDTH-1:0] enz;
      logic [WIDTH-1:0] eneg;
      ref_csd(v, enz, eneg);
      chk(dig_nz == enz, "R3", "nonzero flags", dig_nz, enz);
      chk((dig_neg & enz) == eneg, "R3", "sign flags", dig_neg, eneg);
      chk((dig_neg & ~dig_nz) == '0, "R4", "bare sign code 01", dig_neg & ~dig_nz, 0);
      chk(weigh(dig_nz, dig_neg) == longint'($signed(v)), "R5", "weighted sum",
          weigh(dig_nz, dig_neg), longint'($signed(v)));
      chk((dig_nz & (dig_nz >> 1)) == '0, "R6", "adjacent nonzero", dig_nz & (dig_nz >> 1), 0);
      chk(nz_count == CW'($countones(enz)), "R7", "nonzero count", nz_count, $countones(enz));
   endtask

   // drive start at a falling edge; optionally raise a second start mid-run
   task automatic convert(input logic [WIDTH-1:0] v, input bit poke, input logic [WIDTH-1:0] other);
      bit early = 1'b0;
      bit idle_seen = 1'b0;
      value = v;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      value = ~v;
      chk(busy === 1'b1, "R11", "busy after accept", busy, 1);
      for (int j = 1; j <= WIDTH; j++) begin
         if (poke && j == 3) begin
            start = 1'b1;
            value = other;
         end
         @(negedge clk);
         start = 1'b0;
         if (j < WIDTH) begin
            if (done !== 1'b0) early = 1'b1;
            if (busy !== 1'b1) idle_seen = 1'b1;
         end
      end
      chk(!early, "R8", "done before WIDTH edges", early, 0);
      chk(!idle_seen, "R11", "busy dropped early", idle_seen, 0);
      chk(done === 1'b1, poke ? "R9" : "R8", "done at WIDTH edges", done, 1);
      chk(busy === 1'b0, "R11", "busy low with done", busy, 0);
      check_result(v);
      @(negedge clk);
      chk(done === 1'b0, "R8", "done single cycle", done, 0);
   endtask

   initial begin : watchdog
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [WIDTH-1:0] held_nz;
      logic [WIDTH-1:0] held_neg;
      logic [CW-1:0]    held_cnt;
      logic [WIDTH-1:0] r;
      void'($urandom(32'h5EED_0C5D));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done after reset", {busy, done}, 0);
      chk(dig_nz === '0 && dig_neg === '0 && nz_count === '0, "R1", "digits after reset",
          dig_nz | dig_neg, 0);

      // directed corners
      convert(16'h0000, 1'b0, '0);
      convert(16'h0001, 1'b0, '0);
      convert(16'hFFFF, 1'b0, '0);
      // R2 most negative value: single -1 on top
      convert(16'h8000, 1'b0, '0);
      chk(dig_nz == 16'h8000 && dig_neg == 16'h8000, "R2", "most negative", dig_nz, 16'h8000);
      convert(16'h7FFF, 1'b0, '0);
      convert(16'h5555, 1'b0, '0);
      convert(16'hAAAA, 1'b0, '0);
      convert(16'h3333, 1'b0, '0);
      convert(16'hC001, 1'b0, '0);
      convert(16'h8001, 1'b0, '0);

      // R9 start during a run is ignored
      convert(16'h1234, 1'b1, 16'hFFFF);
      convert(16'h8000, 1'b1, 16'h7FFF);

      // R10 idle hold while value wiggles
      convert(16'h6DB7, 1'b0, '0);
      held_nz = dig_nz;
      held_neg = dig_neg;
      held_cnt = nz_count;
      for (int k = 0; k < 4; k++) begin
         value = 16'($urandom);
         @(negedge clk);
      end
      chk(dig_nz == held_nz && dig_neg == held_neg && nz_count == held_cnt, "R10",
          "result held while idle", {dig_nz, dig_neg}, {held_nz, held_neg});

      // constrained random: alternate full-range and sparse operands
      for (int n = 0; n < RANDOM_RUNS; n++) begin
         r = 16'($urandom);
         if (n % 3 == 1) r = r & 16'($urandom) & 16'($urandom);
         if (n % 3 == 2) r = r | 16'($urandom) | 16'($urandom);
         convert(r, (n % 97) == 5, 16'($urandom));
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule